// File: doc/BRIEF.md
# Parallel PRBS Generator with Single-Bit Error Injection

This block produces a pseudo-random bit stream 32 bits at a time, one word per clock of the serializer-side parallel clock. A 2-bit selector picks one of four maximal-length polynomials at run time. A polarity input can complement every generated bit. While the block is idle, or on the cycle its polynomial selector changes, it reloads an all-ones seed. The word produced next therefore starts the sequence from its beginning.

For link testing, a one-cycle inject request with a 5-bit index flips exactly one bit of exactly one output word. The flip is applied after the polarity inversion, so the receiver always sees one mismatch. The request clears itself. If the generator is not producing a word when the request arrives, the request waits for the next word it produces.

Top module: `prbs_gen_inj`

## Requirements
- R1: While `rst_n` is low, `valid_o` and `data_o` are zero after the next clock edge.
- R2: The selector `poly_sel_i` picks the recurrence b[k] = b[k-N] xor b[k-M], with (N,M) = (7,6) for 2'b00, (9,5) for 2'b01, (23,18) for 2'b10 and (31,28) for 2'b11. Bit 0 of each word is the earliest bit in serial order.
- R3: The history starts as all ones when the block leaves idle and on the cycle `poly_sel_i` differs from the polynomial in use. That cycle yields no valid word, and the next word starts from the seed.
- R4: While `en_i` and `gen_mode_i` are both high and the selector is unchanged, every clock yields a valid 32-bit word that continues the sequence. For the 7-bit polynomial, the word 127 words later equals the first word.
- R5: When `invert_i` is high, every bit of the word is complemented. When it is low, no bit is complemented.
- R6: An inject request `inject_i` in a producing cycle flips only bit `err_idx_i` of that word, after inversion. The following words carry no flip.
- R7: A request in a non-producing cycle keeps its index and is applied to the next produced word. A second request made while one is waiting is absorbed.
- R8: If `en_i` or `gen_mode_i` is low, `valid_o` and `data_o` are zero after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (serializer-side) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable |
| gen_mode_i | input | 1 | Generator mode select; must be high to produce words |
| poly_sel_i | input | 2 | Polynomial select (00:7, 01:9, 10:23, 11:31) |
| invert_i | input | 1 | Complement all generated bits |
| err_idx_i | input | 5 | Bit position for injected error |
| inject_i | input | 1 | One-cycle inject request |
| data_o | output | 32 | Pattern word, bit 0 first in serial order |
| valid_o | output | 1 | Word valid strobe |

## Verification
An error injection and a seed reload can both fall in the same cycle. The bench provokes this in two ways. It raises the inject request on the very cycle the polynomial selector changes. It also raises the request while the block is idle, then a second one before enabling. The reference model must find the flip on the first word of the restarted sequence, at the first request's index only, with every later word clean. Separately, a sweep of all 32 indices under both polarities confirms that each injection flips exactly the chosen bit of one word.

// File: rtl/prbs_gen_pkg.sv
// Package: constants and helpers shared by the PRBS generator.
// Assumes polynomials of the form x^N + x^M + 1 with 2 <= M < N <= 31.
package prbs_gen_pkg;

    localparam int NUM_POLY = 4;
    localparam int MAX_LEN  = 31;

    // Register length for each polynomial code.
    function automatic int poly_len(input int code);
        case (code)
            0:       return 7;
            1:       return 9;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Inner feedback tap for each polynomial code.
    function automatic int poly_tap(input int code);
        case (code)
            0:       return 6;
            1:       return 5;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

    // All-ones seed sized to the selected register length.
    function automatic logic [MAX_LEN-1:0] seed_of(input logic [1:0] code);
        return {MAX_LEN{1'b1}} >> (MAX_LEN - poly_len(int'(code)));
    endfunction

endpackage

// File: rtl/prbs_lfsr_adv.sv
// Module: advances one Fibonacci LFSR by WORD_W steps in one cycle.
// Purely combinational. Bit i of word_o is the (i+1)-th new bit produced.
// Assumes LEN > TAP >= 1 and LEN >= 2.
module prbs_lfsr_adv #(
    parameter int LEN    = 7,
    parameter int TAP    = 6,
    parameter int WORD_W = 32
) (
    input  logic [LEN-1:0]    state_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LEN-1:0]    next_o
);

    logic [LEN-1:0] walk;
    logic           fb;

    // Unroll WORD_W steps of b[k] = b[k-LEN] ^ b[k-TAP]; state_i[0] is newest.
    always_comb begin
        walk   = state_i;
        word_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            fb        = walk[LEN-1] ^ walk[TAP-1];
            word_o[i] = fb;
            walk      = {walk[LEN-2:0], fb};
        end
        next_o = walk;
    end

endmodule

// File: rtl/prbs_err_inject.sv
// Module: turns a one-cycle inject request into a one-hot flip mask that
// is applied to exactly one produced word. A request made while no word is
// produced is held; further requests while one is held are absorbed.
// Assumes synchronous active-low reset.
module prbs_err_inject #(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              consume_i,
    output logic [WORD_W-1:0] mask_o
);

    logic             pending_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] use_idx;
    logic             have_req;

    // Pick a held request over a fresh one and form the flip mask.
    always_comb begin
        have_req = pending_q | req_i;
        use_idx  = pending_q ? idx_q : idx_i;
        mask_o   = '0;
        if (consume_i && have_req) begin
            mask_o[use_idx] = 1'b1;
        end
    end

    // Hold a request until a word consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            idx_q     <= '0;
        end else if (consume_i) begin
            pending_q <= 1'b0;
        end else if (req_i && !pending_q) begin
            pending_q <= 1'b1;
            idx_q     <= idx_i;
        end
    end

    // A produced word always empties the request slot.
    p_consume_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !pending_q);

    // A held request keeps its index until a word takes it.
    p_hold_until_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !consume_i) |=> (pending_q && $stable(idx_q)));

endmodule

// File: rtl/prbs_gen_inj.sv
// Module: parallel PRBS generator, WORD_W bits per clock, four run-time
// selectable polynomials, polarity inversion and single-bit error injection.
// Assumes: synchronous active-low reset; inject_i is a one-cycle request.
module prbs_gen_inj
    import prbs_gen_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              gen_mode_i,
    input  logic [1:0]        poly_sel_i,
    input  logic              invert_i,
    input  logic [IDX_W-1:0]  err_idx_i,
    input  logic              inject_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);

    logic [MAX_LEN-1:0] state_q;
    logic [1:0]         poly_q;
    logic               active;
    logic               producing;
    logic [WORD_W-1:0]  word_arr [NUM_POLY];
    logic [MAX_LEN-1:0] next_arr [NUM_POLY];
    logic [WORD_W-1:0]  inj_mask;

    // A word is produced only while enabled and the selector is settled.
    always_comb begin
        active    = en_i & gen_mode_i;
        producing = active && (poly_sel_i == poly_q);
    end

    // One advance unit per supported polynomial.
    for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
        localparam int L = poly_len(g);
        localparam int T = poly_tap(g);
        logic [L-1:0] nxt;

        prbs_lfsr_adv #(.LEN(L), .TAP(T), .WORD_W(WORD_W)) u_adv (
            .state_i (state_q[L-1:0]),
            .word_o  (word_arr[g]),
            .next_o  (nxt)
        );

        if (L < MAX_LEN) begin : g_pad
            assign next_arr[g] = {{(MAX_LEN-L){1'b0}}, nxt};
        end else begin : g_full
            assign next_arr[g] = nxt;
        end
    end

    prbs_err_inject #(.WORD_W(WORD_W)) u_inj (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (inject_i),
        .idx_i     (err_idx_i),
        .consume_i (producing),
        .mask_o    (inj_mask)
    );

    // Reload the seed when idle or on a selector change, else advance and emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_q  <= 2'b00;
            state_q <= seed_of(2'b00);
            data_o  <= '0;
            valid_o <= 1'b0;
        end else if (!producing) begin
            poly_q  <= poly_sel_i;
            state_q <= seed_of(poly_sel_i);
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            state_q <= next_arr[poly_q];
            data_o  <= word_arr[poly_q] ^ {WORD_W{invert_i}} ^ inj_mask;
            valid_o <= 1'b1;
        end
    end

    // A maximal-length register never falls into the all-zero lock state.
    p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // A selector change costs one cycle without a valid word.
    p_change_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && poly_sel_i != poly_q) |=> !valid_o);

    // A valid word needs both enable and generator mode on the prior edge.
    p_valid_needs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(active));

    // Idle output is all zero.
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (data_o == '0));

endmodule

// File: tb/sim_prbs_gen_inj.sv
// Bench: bit-serial reference model of the recurrence, compared word by word.
module sim_prbs_gen_inj;

    localparam time CLK_PERIOD = 10ns;
    localparam int  W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         gen_mode_i = 1'b0;
    logic [1:0]   poly_sel_i = 2'b00;
    logic         invert_i = 1'b0;
    logic [4:0]   err_idx_i = '0;
    logic         inject_i = 1'b0;
    logic [W-1:0] data_o;
    logic         valid_o;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    int           mpoly = 0;
    logic [30:0]  hist = '1;
    logic         mpend = 1'b0;
    logic [4:0]   midx = '0;
    logic [W-1:0] exp_data = '0;
    logic         exp_valid = 1'b0;
    logic [W-1:0] first_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_gen_inj #(.WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .gen_mode_i(gen_mode_i),
        .poly_sel_i(poly_sel_i), .invert_i(invert_i), .err_idx_i(err_idx_i),
        .inject_i(inject_i), .data_o(data_o), .valid_o(valid_o)
    );

    function automatic int len_of(int p);
        return (p == 0) ? 7 : (p == 1) ? 9 : (p == 2) ? 23 : 31;
    endfunction

    function automatic int tap_of(int p);
        return (p == 0) ? 6 : (p == 1) ? 5 : (p == 2) ? 18 : 28;
    endfunction

    // Predict the outputs of the coming edge from the present inputs.
    task automatic model_edge();
        logic [W-1:0] w;
        logic [W-1:0] mask;
        logic         b;
        if (!rst_n) begin
            mpoly = 0; hist = '1; mpend = 1'b0;
            exp_data = '0; exp_valid = 1'b0;
            return;
        end
        if (!(en_i && gen_mode_i) || int'(poly_sel_i) != mpoly) begin
            mpoly = int'(poly_sel_i);
            hist = '1;
            exp_data = '0; exp_valid = 1'b0;
            if (inject_i && !mpend) begin
                mpend = 1'b1; midx = err_idx_i;
            end
        end else begin
            for (int i = 0; i < W; i++) begin
                b = hist[len_of(mpoly)-1] ^ hist[tap_of(mpoly)-1];
                w[i] = b;
                hist = {hist[29:0], b};
            end
            mask = '0;
            if (mpend) mask[midx] = 1'b1;
            else if (inject_i) mask[err_idx_i] = 1'b1;
            mpend = 1'b0;
            exp_data = w ^ {W{invert_i}} ^ mask;
            exp_valid = 1'b1;
        end
    endtask

    task automatic tick(string tag);
        model_edge();
        @(posedge clk);
        #1;
        n_checks++;
        if (data_o !== exp_data || valid_o !== exp_valid) begin
            n_errs++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     tag, data_o, valid_o, exp_data, exp_valid);
        end
    endtask

    task automatic pulse_inject(int idx, string tag);
        err_idx_i = 5'(idx);
        inject_i = 1'b1;
        tick(tag);
        inject_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        #1;
        for (int i = 0; i < 3; i++) tick("R1 reset");
        rst_n = 1'b1;

        // R4: continuous PRBS-7 words, and its 127-word period
        en_i = 1'b1; gen_mode_i = 1'b1; poly_sel_i = 2'b00;
        tick("R4 first word");
        first_word = data_o;
        for (int i = 0; i < 126; i++) tick("R4 run");
        tick("R4 run");
        n_checks++;
        if (data_o !== first_word) begin
            n_errs++;
            $display("FAIL R4 period: data=%h expected=%h", data_o, first_word);
        end

        // R2 R5: every polynomial under both polarities
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 2; v++) begin
                poly_sel_i = 2'(p);
                invert_i = v[0];
                for (int i = 0; i < 30; i++) tick(v ? "R5 inverted" : "R2 polynomial");
            end
        end

        // R8: mode low or enable low gives no words; R3 restart from seed
        gen_mode_i = 1'b0;
        for (int i = 0; i < 4; i++) tick("R8 mode low");
        gen_mode_i = 1'b1;
        for (int i = 0; i < 4; i++) tick("R3 restart");
        en_i = 1'b0;
        for (int i = 0; i < 3; i++) tick("R8 enable low");
        en_i = 1'b1;
        for (int i = 0; i < 3; i++) tick("R3 restart");
        poly_sel_i = 2'b01;
        for (int i = 0; i < 4; i++) tick("R3 selector change");

        // R6: sweep every bit index, both polarities
        poly_sel_i = 2'b11;
        tick("R3 selector change");
        for (int k = 0; k < 32; k++) begin
            invert_i = k[0];
            pulse_inject(k, "R6 inject sweep");
            tick("R6 clean after");
            tick("R6 clean after");
        end

        // R7: request while idle waits for the first produced word
        en_i = 1'b0;
        pulse_inject(17, "R7 held");
        tick("R7 held");
        en_i = 1'b1;
        for (int i = 0; i < 3; i++) tick("R7 applied");

        // R7: request on the same cycle as a selector change
        poly_sel_i = 2'b10;
        pulse_inject(4, "R7 with reload");
        for (int i = 0; i < 3; i++) tick("R7 after reload");

        // R7: second request while one waits is absorbed
        en_i = 1'b0;
        pulse_inject(3, "R7 first request");
        pulse_inject(9, "R7 second request");
        en_i = 1'b1;
        for (int i = 0; i < 3; i++) tick("R7 absorbed");

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        tick("R1 reset again");
        tick("R1 reset again");
        finish_run();
    end

endmodule